// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block opens and closes up to eight per-priority transmit gates from a list of timed entries held in a local fetch memory. Each entry carries a duration, counted in wire-side clock cycles, and a gate mask. The scheduler applies the entries one after another. An external cycle-start pulse, produced by a separate cycle-time generator, restarts the list at its first entry. The gate mask therefore follows a schedule that repeats once per cycle.

The 128-word memory works in one of two modes. In split mode it holds two 64-entry lists. One list is executing (the oper list), while software loads a replacement into the other (the admin list). A swap request arms the exchange, and the roles change at the next cycle start, so the schedule never switches in the middle of a cycle. In single mode all 128 words form one longer list. While the scheduler is disabled, every gate stays open.

The controller has three named states:
- `ST_OFF`: scheduler disabled or not yet started; all gates open.
- `ST_RUN`: counting down the current entry.
- `ST_HOLD`: list finished; the last mask is frozen until the next cycle start.

The transitions are:
- `ST_OFF` goes to `ST_RUN`, or to `ST_HOLD`, on an enabled cycle start.
- `ST_RUN` goes to `ST_RUN` to load the next entry, and to `ST_HOLD` at a zero-count entry or at the end of the buffer.
- `ST_RUN` and `ST_HOLD` restart on a cycle start.
- Any state returns to `ST_OFF` when the enable drops.

Top module: `gate_sched_top`

## Requirements
- R1: A 22-bit entry holds a duration in bits [21:8] and a gate mask in bits [7:0]. After a cycle-start edge, entry 0's mask appears on `gate_mask` and stays for exactly its duration in clock cycles. Each later entry follows with no gap cycle, and `entry_idx` shows the index of the applied entry within its buffer.
- R2: A cycle start while enabled restarts the list at entry 0 of the active buffer, including in the middle of an entry, and sets `entry_idx` to 0.
- R3: An entry with duration zero ends the list. The previous entry's mask and index are held until the next cycle start. If entry 0 has duration zero, all gates are open and `entry_idx` is 0.
- R4: After the last location of the active buffer has run (index 63 in split mode, 127 in single mode), its mask and index are held until the next cycle start.
- R5: In split mode (`split_mode`=1), write-address bit 6 selects the buffer. A write whose bit 6 equals `oper_sel` is ignored and leaves the running list unchanged.
- R6: In single mode (`split_mode`=0), all 128 addresses are writable, including during execution. The list runs from address 0 through address 127.
- R7: In split mode, `swap_req` sets `swap_pending` in the next cycle. At the next cycle start, `oper_sel` inverts, `swap_pending` clears, and the new list runs from that start. In single mode, `swap_pending` is 0 and `swap_req` has no effect.
- R8: `oper_sel` changes only on a cycle-start edge.
- R9: With `sched_en`=0, `gate_mask` is all ones and `entry_idx` is 0 from the next cycle on. After enabling, all gates stay open until the next cycle start.
- R10: After reset, `gate_mask` is all ones, `oper_sel`, `swap_pending` and `entry_idx` are 0, and every memory word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_en | input | 1 | Scheduler enable |
| split_mode | input | 1 | 1: two 64-entry buffers; 0: one 128-entry buffer |
| cycle_start | input | 1 | One-cycle pulse marking a schedule cycle boundary |
| swap_req | input | 1 | Request to exchange the oper and admin buffers |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 7 | Entry write address |
| wr_data | input | 22 | Entry value: duration [21:8], mask [7:0] |
| gate_mask | output | 8 | Per-priority gate open mask |
| oper_sel | output | 1 | Buffer that is executing in split mode |
| swap_pending | output | 1 | Swap armed, waiting for a cycle start |
| entry_idx | output | 7 | Index of the applied entry within its buffer |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Entry boundaries.** An off-by-one count makes every mask one cycle long or short, and the error accumulates along the list.
- **Zero-count terminator and end of buffer.** A faulty design would run past the list into stale words, or drop the held mask back to all-open.
- **Writes aimed at the running half.** If these were not ignored, the next cycle would replay a corrupted schedule.
- **Swap timing.** A swap that happened on the request rather than at the boundary would start the new list mid-cycle.
- **Enabling between boundaries, and a restart in the middle of an entry.** A faulty design would start the schedule early, or keep counting the old entry after the restart.

// File: rtl/gsched_pkg.sv
package gsched_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } sched_state_t;

endpackage

// File: rtl/gsched_fetch_ram.sv
module gsched_fetch_ram #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 22,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/gsched_buf_ctrl.sv
module gsched_buf_ctrl #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split_mode,
    input  logic          cycle_start,
    input  logic          swap_req,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output logic          oper_sel,
    output logic          swap_pending,
    output logic          swap_now,
    output logic          wr_ok
);

    // Exchange happens only on a boundary with an armed request.
    assign swap_now = cycle_start & swap_pending & split_mode;

    // In split mode the top address bit names the half; the running half is locked.
    assign wr_ok = wr_en & (~split_mode | (wr_addr[AW-1] != oper_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oper_sel     <= 1'b0;
            swap_pending <= 1'b0;
        end else begin
            if (swap_now) begin
                oper_sel <= ~oper_sel;
            end
            if (!split_mode) begin
                swap_pending <= 1'b0;
            end else if (swap_now) begin
                swap_pending <= 1'b0;
            end else if (swap_req) begin
                swap_pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gsched_fsm.sv
module gsched_fsm
    import gsched_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int MASK_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic              cycle_start,
    input  logic [AW-1:0]     last_idx,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic [MASK_W-1:0] rd_mask,
    output logic [AW-1:0]     rd_idx,
    output logic [MASK_W-1:0] gate_mask,
    output logic [AW-1:0]     entry_idx
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    sched_state_t      state, nxt_state;
    logic [CNT_W-1:0]  cnt_q, nxt_cnt;
    logic [MASK_W-1:0] mask_q, nxt_mask;
    logic [AW-1:0]     idx_q, nxt_idx;

    // The fetch address is the list head on a boundary, otherwise the successor.
    assign rd_idx = cycle_start ? '0 : idx_q + AW'(1);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt_q;
        nxt_mask  = mask_q;
        nxt_idx   = idx_q;
        unique case (state)
            ST_OFF: begin
                nxt_mask = '1;
                nxt_idx  = '0;
                if (sched_en && cycle_start) begin
                    nxt_idx = '0;
                    if (rd_cnt == '0) begin
                        nxt_state = ST_HOLD;
                    end else begin
                        nxt_state = ST_RUN;
                        nxt_cnt   = rd_cnt;
                        nxt_mask  = rd_mask;
                    end
                end
            end
            ST_RUN, ST_HOLD: begin
                if (!sched_en) begin
                    nxt_state = ST_OFF;
                    nxt_mask  = '1;
                    nxt_idx   = '0;
                end else if (cycle_start) begin
                    nxt_idx = '0;
                    if (rd_cnt == '0) begin
                        nxt_state = ST_HOLD;
                        nxt_mask  = '1;
                    end else begin
                        nxt_state = ST_RUN;
                        nxt_cnt   = rd_cnt;
                        nxt_mask  = rd_mask;
                    end
                end else if (state == ST_RUN) begin
                    if (cnt_q != CNT_ONE) begin
                        nxt_cnt = cnt_q - CNT_ONE;
                    end else if (idx_q == last_idx || rd_cnt == '0) begin
                        nxt_state = ST_HOLD;
                    end else begin
                        nxt_cnt  = rd_cnt;
                        nxt_mask = rd_mask;
                        nxt_idx  = rd_idx;
                    end
                end
            end
            default: begin
                nxt_state = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt_q  <= '0;
            mask_q <= '1;
            idx_q  <= '0;
        end else begin
            state  <= nxt_state;
            cnt_q  <= nxt_cnt;
            mask_q <= nxt_mask;
            idx_q  <= nxt_idx;
        end
    end

    always_comb begin
        gate_mask = (state == ST_OFF) ? '1 : mask_q;
        entry_idx = (state == ST_OFF) ? '0 : idx_q;
    end

endmodule

// File: rtl/gate_sched_top.sv
module gate_sched_top #(
    parameter int CNT_W  = 14,
    parameter int MASK_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int EW    = CNT_W + MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic              split_mode,
    input  logic              cycle_start,
    input  logic              swap_req,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [EW-1:0]     wr_data,
    output logic [MASK_W-1:0] gate_mask,
    output logic              oper_sel,
    output logic              swap_pending,
    output logic [AW-1:0]     entry_idx
);

    localparam logic [AW-1:0] LAST_FULL  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LAST_SPLIT = AW'(DEPTH / 2 - 1);

    logic          swap_now, wr_ok, rd_sel;
    logic [AW-1:0] rd_idx, rd_addr, last_idx;
    logic [EW-1:0] rd_word;

    gsched_buf_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .split_mode   (split_mode),
        .cycle_start  (cycle_start),
        .swap_req     (swap_req),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .oper_sel     (oper_sel),
        .swap_pending (swap_pending),
        .swap_now     (swap_now),
        .wr_ok        (wr_ok)
    );

    // A boundary with a swap fetches its head entry from the incoming half.
    assign rd_sel   = swap_now ? ~oper_sel : oper_sel;
    assign rd_addr  = split_mode ? {rd_sel, rd_idx[AW-2:0]} : rd_idx;
    assign last_idx = split_mode ? LAST_SPLIT : LAST_FULL;

    gsched_fetch_ram #(.DEPTH(DEPTH), .WIDTH(EW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    gsched_fsm #(.CNT_W(CNT_W), .MASK_W(MASK_W), .AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sched_en    (sched_en),
        .cycle_start (cycle_start),
        .last_idx    (last_idx),
        .rd_cnt      (rd_word[EW-1:MASK_W]),
        .rd_mask     (rd_word[MASK_W-1:0]),
        .rd_idx      (rd_idx),
        .gate_mask   (gate_mask),
        .entry_idx   (entry_idx)
    );

endmodule

// File: rtl/gsched_chk.sv
module gsched_chk #(
    parameter int MASK_W = 8,
    parameter int AW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sched_en,
    input logic              split_mode,
    input logic              cycle_start,
    input logic              swap_req,
    input logic [MASK_W-1:0] gate_mask,
    input logic              oper_sel,
    input logic              swap_pending,
    input logic [AW-1:0]     entry_idx
);

    // R9
    gates_open_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> (gate_mask == '1) && (entry_idx == '0));

    // R2
    restart_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_en && cycle_start) |=> (entry_idx == '0) || !sched_en);

    // R8
    oper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(oper_sel));

    // R7
    swap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && cycle_start && split_mode) |=> (oper_sel != $past(oper_sel)) && !swap_pending);

    // R7
    pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && split_mode && !cycle_start) |=> swap_pending);

    // R7
    pending_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |=> !swap_pending);

endmodule

bind gate_sched_top gsched_chk #(.MASK_W(MASK_W), .AW(AW)) u_gsched_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sched_en     (sched_en),
    .split_mode   (split_mode),
    .cycle_start  (cycle_start),
    .swap_req     (swap_req),
    .gate_mask    (gate_mask),
    .oper_sel     (oper_sel),
    .swap_pending (swap_pending),
    .entry_idx    (entry_idx)
);

// File: tb/test_gate_sched_top.sv
`timescale 1ns/1ps
module test_gate_sched_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_en = 1'b0;
    logic        split_mode = 1'b1;
    logic        cycle_start = 1'b0;
    logic        swap_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic [7:0]  gate_mask;
    logic        oper_sel;
    logic        swap_pending;
    logic [6:0]  entry_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit exp_sel = 0;
    bit exp_pend = 0;
    logic [21:0] shadow [128];

    always #5 clk = ~clk;

    gate_sched_top i_gate_sched_top (
        .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .split_mode(split_mode),
        .cycle_start(cycle_start), .swap_req(swap_req), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .gate_mask(gate_mask),
        .oper_sel(oper_sel), .swap_pending(swap_pending), .entry_idx(entry_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected mask and index k cycles after a list start (R1, R3, R4).
    function automatic void model(input int base, input int len, input int k,
                                  output logic [7:0] m, output int ix);
        int rem = k;
        m = 8'hFF;
        ix = 0;
        for (int i = 0; i < len; i++) begin
            int c = int'(shadow[base + i][21:8]);
            if (c == 0) return;
            m = shadow[base + i][7:0];
            ix = i;
            if (rem < c) return;
            rem -= c;
        end
    endfunction

    function automatic int list_len(input int base, input int len);
        int s = 0;
        for (int i = 0; i < len; i++) begin
            if (shadow[base + i][21:8] == 0) return s;
            s += int'(shadow[base + i][21:8]);
        end
        return s;
    endfunction

    task automatic wr(input int addr, input logic [21:0] d);
        wr_en = 1'b1;
        wr_addr = 7'(addr);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!split_mode || (addr[6] != exp_sel)) shadow[addr] = d;
    endtask

    task automatic request_swap();
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        if (split_mode) exp_pend = 1;
        check("R7 pending", int'(swap_pending), int'(exp_pend));
    endtask

    // Pulse a boundary, then compare n cycles against the model.
    task automatic run_check(input string req, input int n);
        int base, len, ix;
        logic [7:0] m;
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        if (split_mode && exp_pend) begin
            exp_sel = ~exp_sel;
            exp_pend = 0;
        end
        base = split_mode ? (exp_sel ? 64 : 0) : 0;
        len = split_mode ? 64 : 128;
        check("R7 sel", int'(oper_sel), int'(exp_sel));
        check("R7 pend clear", int'(swap_pending), 0);
        for (int k = 0; k < n; k++) begin
            model(base, len, k, m, ix);
            check({req, " mask"}, int'(gate_mask), int'(m));
            check({req, " idx"}, int'(entry_idx), ix);
            @(negedge clk);
        end
    endtask

    task automatic fill(input int base, input int n, input int maxc, input bit term);
        for (int i = 0; i < n; i++)
            wr(base + i, {14'(1 + ($urandom % maxc)), 8'($urandom)});
        if (term) wr(base + n, 22'h0000A5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 mask", int'(gate_mask), 8'hFF);
        check("R10 sel", int'(oper_sel), 0);
        check("R10 pend", int'(swap_pending), 0);
        check("R10 idx", int'(entry_idx), 0);

        // R5: load admin half, attempt a write into the running half
        sched_en = 1'b1;
        fill(64, 12, 5, 1);
        wr(0, {14'd3, 8'h3C});
        check("R5 ignored shadow", int'(shadow[0]), 0);
        run_check("R3 empty head R5", 6);

        // R7 and R8: arm swap, no change before the boundary
        request_swap();
        repeat (4) @(negedge clk);
        check("R8 sel held", int'(oper_sel), 0);
        check("R7 still pending", int'(swap_pending), 1);
        run_check("R1 R3 list", list_len(64, 64) + 4);

        // R5: write to oper half ignored; admin half filled to the end
        wr(64, {14'd9, 8'h00});
        fill(0, 64, 3, 0);
        run_check("R5 replay", list_len(64, 64) + 3);

        // R2: restart mid-entry
        run_check("R2 partial", 5);
        run_check("R2 restart", 8);

        // R4: split-buffer end
        request_swap();
        run_check("R4 split end", list_len(0, 64) + 5);

        // R9: disable and late enable
        sched_en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R9 off mask", int'(gate_mask), 8'hFF);
            check("R9 off idx", int'(entry_idx), 0);
            @(negedge clk);
        end
        sched_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check("R9 wait start", int'(gate_mask), 8'hFF);
            @(negedge clk);
        end
        run_check("R9 resumed", 6);

        // R6 and R4: single 128-entry list, swap ignored
        split_mode = 1'b0;
        @(negedge clk);
        exp_pend = 0;
        fill(0, 128, 2, 0);
        request_swap();
        check("R7 single no pend", int'(swap_pending), 0);
        run_check("R6 R4 single", list_len(0, 128) + 5);

        // Random split-mode lists with swaps
        split_mode = 1'b1;
        @(negedge clk);
        for (int it = 0; it < 6; it++) begin
            int n = 1 + ($urandom % 20);
            fill(exp_sel ? 0 : 64, n, 6, 1);
            request_swap();
            run_check("R1 random", list_len(exp_sel ? 0 : 64, 64) + 3);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule